// File: doc/BRIEF.md
# Dual-Mode Extended Sequencer Registers

This block holds the extended sequencer registers of an SVGA-style display controller, at indices 0x0B to 0x0F. Software reaches them through a byte-wide index register and a data port. The index register is loaded by one strobe. Data writes and data reads use their own single-cycle strobes. Read data is combinational from the current index.

Two registers, 0x0D and 0x0E, each have two copies: an old-mode copy and a new-mode copy. An access to index 0x0B chooses which copy is live. Reading 0x0B returns a fixed identification byte and switches to the new set. Writing 0x0B switches back to the old set.

The block also drives three outputs:
- a post-port location flag, taken from index 0x0C;
- a 4-bit pixel clock select, built when the new-mode copy of 0x0D is written;
- a 2-bit clock divide code, read from the new-mode copy of 0x0D.

Top module: `ext_seq_regs`

## Requirements
- R1: After reset the block is in old mode. Every stored register, `clk_sel`, `clk_div` and `post_alt` are 0.
- R2: A read of index 0x0B returns 0xD3. In the cycle after the read strobe, `new_set` is 1.
- R3: A write of any value to index 0x0B clears `new_set` in the next cycle. If a write and a read of 0x0B occur in the same cycle, the write wins.
- R4: Indices 0x0D and 0x0E each keep an independent old-mode copy and new-mode copy. Writes and reads reach the copy that `new_set` selects.
- R5: A new-mode write to 0x0E stores the data with bit 1 inverted, and a read returns the stored byte unchanged. An old-mode write to 0x0E stores the data as written.
- R6: A write to 0x0C stores the byte, and a read of 0x0C returns it. Bit 4 of the stored byte drives `post_alt`: 1 selects the 0x3C3 post port and 0 selects the 0x46E8 post port.
- R7: A new-mode write to 0x0D loads `clk_sel` with {data[6], data[0], misc_sel[1:0]}, with data[6] as the most significant bit. An old-mode write to 0x0D leaves `clk_sel` unchanged.
- R8: `clk_div` equals bits 2:1 of the new-mode copy of 0x0D. The codes 0, 1, 2 and 3 mean divide by 1, 2, 4 and 1.5.
- R9: Index 0x0F is a plain 8-bit read/write register.
- R10: Any index outside 0x0B to 0x0F reads as 0x00. A write to such an index changes no register and no output.
- R11: An index-strobe write takes effect on the next cycle. The data port then reads the register that the new index names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Strobe that loads the index register from `wdata` |
| dat_wr | input | 1 | Data write strobe to the indexed register |
| dat_rd | input | 1 | Data read strobe; triggers the read side effect at 0x0B |
| wdata | input | 8 | Write data for the index register and the data port |
| misc_sel | input | 2 | Clock-select bits from the miscellaneous output register |
| rdata | output | 8 | Combinational read data for the current index |
| new_set | output | 1 | 1 when the new-mode register set is selected |
| post_alt | output | 1 | Post-port select flag |
| clk_sel | output | 4 | Pixel clock select index |
| clk_div | output | 2 | Clock divide code |

## Verification
The bench builds the block with its default parameters. These are identification byte 0xD3, inversion mask 0x02 on the new-mode 0x0E copy, and post flag at bit 4. The checks therefore compare against the actual values the controller uses.

Random index and data traffic covers several kinds of index:
- values just below the range (0x0A);
- values just above the range (0x10 and up);
- values far outside the range.

Mode switches are mixed into this traffic, so that both copies of 0x0D and 0x0E are written in arbitrary order. Directed cases add two checks. One is a read and a write of 0x0B in the same cycle. The other is a set of exact clock-select and divide patterns.

// File: rtl/ext_seq_regs.sv
module ext_seq_regs #(
  parameter logic [7:0] CHIP_ID  = 8'hD3,
  parameter logic [7:0] NEW_INV  = 8'h02,
  parameter int         POST_BIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  input  logic [1:0] misc_sel,
  output logic [7:0] rdata,
  output logic       new_set,
  output logic       post_alt,
  output logic [3:0] clk_sel,
  output logic [1:0] clk_div
);
  logic [7:0] idx_q, r0c, r0d_o, r0d_n, r0e_o, r0e_n, r0f;
  logic       mode_q;
  logic [3:0] clk_q;

  wire at_b = (idx_q == 8'h0B);
  wire at_c = (idx_q == 8'h0C);
  wire at_d = (idx_q == 8'h0D);
  wire at_e = (idx_q == 8'h0E);
  wire at_f = (idx_q == 8'h0F);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      r0c    <= '0;
      r0d_o  <= '0;
      r0d_n  <= '0;
      r0e_o  <= '0;
      r0e_n  <= '0;
      r0f    <= '0;
      mode_q <= 1'b0;
      clk_q  <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (dat_wr && at_c) r0c <= wdata;
      if (dat_wr && at_f) r0f <= wdata;
      if (dat_wr && at_d) begin
        if (mode_q) begin
          r0d_n <= wdata;
          clk_q <= {wdata[6], wdata[0], misc_sel};
        end else begin
          r0d_o <= wdata;
        end
      end
      if (dat_wr && at_e) begin
        if (mode_q) r0e_n <= wdata ^ NEW_INV;
        else        r0e_o <= wdata;
      end
      if (dat_wr && at_b)      mode_q <= 1'b0;
      else if (dat_rd && at_b) mode_q <= 1'b1;
    end
  end

  always_comb begin
    case (idx_q)
      8'h0B:   rdata = CHIP_ID;
      8'h0C:   rdata = r0c;
      8'h0D:   rdata = mode_q ? r0d_n : r0d_o;
      8'h0E:   rdata = mode_q ? r0e_n : r0e_o;
      8'h0F:   rdata = r0f;
      default: rdata = 8'h00;
    endcase
  end

  assign new_set  = mode_q;
  assign post_alt = r0c[POST_BIT];
  assign clk_sel  = clk_q;
  assign clk_div  = r0d_n[2:1];

  wire undef_idx = !(at_b || at_c || at_d || at_e || at_f);

  assert_id_read_new_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !dat_wr && at_b) |=> new_set);
  assert_write_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && at_b) |=> !new_set);
  assert_post_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && at_c) |=> post_alt == $past(wdata[POST_BIT]));
  assert_clk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && at_d && new_set) |=> $stable(clk_sel));
  assert_div_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && at_d && new_set) |=> clk_div == $past(wdata[2:1]));
  assert_undef_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && undef_idx && !dat_rd) |=>
      $stable({r0c, r0d_o, r0d_n, r0e_o, r0e_n, r0f, clk_q, mode_q}));
endmodule

// File: tb/sim_ext_seq_regs.sv
module sim_ext_seq_regs;
  logic clk = 0, rst_n = 0, idx_wr = 0, dat_wr = 0, dat_rd = 0;
  logic [7:0] wdata = 0;
  logic [1:0] misc_sel = 0;
  logic [7:0] rdata;
  logic new_set, post_alt;
  logic [3:0] clk_sel;
  logic [1:0] clk_div;

  ext_seq_regs u0 (.clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .dat_rd(dat_rd), .wdata(wdata), .misc_sel(misc_sel), .rdata(rdata),
    .new_set(new_set), .post_alt(post_alt), .clk_sel(clk_sel), .clk_div(clk_div));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] cur = 0, m0c = 0, m0f = 0;
  logic [7:0] m0d [2];
  logic [7:0] m0e [2];
  logic mnew = 0;
  logic [3:0] mclk = 0;

  function automatic logic [7:0] exp_rd(logic [7:0] i);
    case (i)
      8'h0B: return 8'hD3;
      8'h0C: return m0c;
      8'h0D: return m0d[mnew];
      8'h0E: return m0e[mnew];
      8'h0F: return m0f;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] i);
    case (i)
      8'h0B: return "R2";
      8'h0C: return "R6";
      8'h0D, 8'h0E: return "R4";
      8'h0F: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_outs();
    chk("R3", {7'd0, new_set}, {7'd0, mnew});
    chk("R6", {7'd0, post_alt}, {7'd0, m0c[4]});
    chk("R7", {4'd0, clk_sel}, {4'd0, mclk});
    chk("R8", {6'd0, clk_div}, {6'd0, m0d[1][2:1]});
  endtask

  task automatic set_idx(logic [7:0] v);
    @(negedge clk); idx_wr = 1; wdata = v;
    @(negedge clk); idx_wr = 0; cur = v;
    chk("R11", rdata, exp_rd(cur));
  endtask

  task automatic wr(logic [7:0] v, logic [1:0] ms);
    @(negedge clk); dat_wr = 1; wdata = v; misc_sel = ms;
    @(negedge clk); dat_wr = 0;
    case (cur)
      8'h0B: mnew = 0;
      8'h0C: m0c = v;
      8'h0D: begin m0d[mnew] = v; if (mnew) mclk = {v[6], v[0], ms}; end
      8'h0E: m0e[mnew] = mnew ? (v ^ 8'h02) : v;
      8'h0F: m0f = v;
      default: ;
    endcase
    chk_outs();
  endtask

  task automatic rd();
    @(negedge clk);
    chk(tag_of(cur), rdata, exp_rd(cur));
    dat_rd = 1;
    @(negedge clk); dat_rd = 0;
    if (cur == 8'h0B) mnew = 1;
    chk_outs();
  endtask

  task automatic rd_all();
    for (int k = 11; k <= 15; k++) begin set_idx(8'(k)); rd(); end
  endtask

  logic done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    m0d[0] = 0; m0d[1] = 0; m0e[0] = 0; m0e[1] = 0;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {new_set, post_alt, clk_sel, clk_div}, 8'h00);
    chk("R1", rdata, 8'h00);
    set_idx(8'h0D); chk("R1", rdata, 8'h00);
    // R2 id read and mode switch
    set_idx(8'h0B); rd(); chk("R2", {7'd0, new_set}, 8'h01);
    // R5 inversion in new mode, none in old mode
    set_idx(8'h0E); wr(8'h00, 2'd0); chk("R5", rdata, 8'h02);
    wr(8'hFF, 2'd0); chk("R5", rdata, 8'hFD);
    // R7 / R8 exact pattern: data bit6=1, bit0=0, misc=3 -> 4'b1011; div code 3
    set_idx(8'h0D); wr(8'h46, 2'd3);
    chk("R7", {4'd0, clk_sel}, 8'h0B); chk("R8", {6'd0, clk_div}, 8'h03);
    // R3 write to 0x0B returns to old mode
    set_idx(8'h0B); wr(8'h5A, 2'd0); chk("R3", {7'd0, new_set}, 8'h00);
    set_idx(8'h0E); wr(8'hFF, 2'd1); chk("R5", rdata, 8'hFF);
    set_idx(8'h0D); wr(8'h41, 2'd2); chk("R7", {4'd0, clk_sel}, 8'h0B);
    chk("R4", rdata, 8'h41);
    // R3 simultaneous read and write of 0x0B: write wins
    set_idx(8'h0B); rd();
    @(negedge clk); dat_rd = 1; dat_wr = 1; wdata = 8'h00;
    @(negedge clk); dat_rd = 0; dat_wr = 0; mnew = 0;
    chk("R3", {7'd0, new_set}, 8'h00);
    // R6 post flag
    set_idx(8'h0C); wr(8'h10, 2'd0); chk("R6", {7'd0, post_alt}, 8'h01);
    wr(8'hEF, 2'd0); chk("R6", {7'd0, post_alt}, 8'h00);
    // R10 undefined writes then full readback
    set_idx(8'h0A); wr(8'hFF, 2'd3); rd();
    set_idx(8'h10); wr(8'hFF, 2'd3); rd();
    rd_all();
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] ix;
      op = $urandom_range(0, 9);
      ix = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'($urandom_range(8'h09, 8'h11));
      if (op < 3) set_idx(ix);
      else if (op < 7) wr(8'($urandom), 2'($urandom));
      else rd();
    end
    rd_all();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule